// File: doc/BRIEF.md
# Backend-Version Aware Register Front End for a Five-Locality TPM FIFO Interface

This block holds the per-locality status and interface-identifier registers of a TPM FIFO-style interface and answers register reads and writes issued as single-cycle strobes with an address and a 32-bit word. The attached backend reports its version (unspecified, 1.2 or 2.0) on a two-bit input. The block captures that version while reset is held and keeps it until the next reset. The captured version selects:

- the capability word,
- the reset contents of the status and interface-identifier registers,
- whether status writes may raise side-effect pulses toward the backend.

A status write can raise two one-cycle pulses toward the backend. One requests cancellation of the running command. The other requests a reset of the establishment flag and carries the requesting locality. Setting the lock bit of the interface identifier from any locality sets it in all five localities, and it stays set until reset.

Address bits 14:12 select the locality and bits 11:0 select the register inside it. The data FIFO, locality arbitration, interrupts and command execution live elsewhere. The FIFO offset reads as zero here. The execution state of each locality is an input to the block.

Top module: `tis_regfront`

## Requirements
- R1: The backend version is captured from `be_ver_i` on every clock with `rst` high, and is held while `rst` is low. The encodings are 0 for unspecified, 1 for version 1.2, 2 for version 2.0, and 3, which is treated as unspecified. Changes on `be_ver_i` outside reset have no effect on any read value or pulse.
- R2: Reading offset 0x14 returns 0x0000_0000 when the version is unspecified. It returns 0x2000_0697 for version 1.2 and 0x3000_0697 for version 2.0. These words are made up of: interface version in bits 31:28, 64-byte transfer size 3 in bits 10:9, dynamic burst count (bit 8 clear), low-level interrupt support in bit 4, and supported interrupt flags 0x87.
- R3: After reset, status (offset 0x18) holds family 1 in bits 27:26, that is 0x0400_0000, for version 2.0. It holds 0 in every other case. The family bits never change outside reset.
- R4: A status write keeps self-test-done (bit 2) and the family field (bits 27:26). It clears every other bit, then sets the written command-ready (bit 6), go (bit 5) and response-retry (bit 1) bits.
- R5: After reset, the interface identifier (offset 0x30) of each locality reads 0xFFFF_FFFF for version 1.2, 0x0000_2100 for version 2.0, and 0 when the version is unspecified.
- R6: A write to offset 0x30 of any locality with bit 19 set sets bit 19 in the interface identifier of all five localities. The other written bits are ignored. Bit 19 then stays set until reset.
- R7: With version 2.0 only, a status write with bit 24 set to a locality whose `exec_state_i` bit is high makes `cancel_o` high for exactly the following cycle.
- R8: With version 2.0 only, a status write with bit 25 set from locality 3 or 4 makes `estab_rst_o` high for the following cycle, with `estab_loc_o` holding that locality. The same write from any other locality is ignored.
- R9: Reading offset 0xF00 returns device ID 0x0001 in bits 31:16 and vendor ID `VENDOR_ID` (0x1014 by default) in bits 15:0. Offset 0x24 and any undecoded offset read as 0.
- R10: Addresses with locality 5, 6 or 7 read as zero, and writes to them change no register and raise no pulse.
- R11: A read strobe returns its data on `rdata_o` with `rvalid_o` high one cycle later. The data is taken from the register state before any write on the same edge. During reset `rvalid_o`, `cancel_o` and `estab_rst_o` are low.
- R12: A high `selftest_done_i` sets bit 2 in the status of all localities, and later status writes keep it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the version is captured while high |
| be_ver_i | input | 2 | Backend version code |
| selftest_done_i | input | 1 | Backend reports self-test complete |
| exec_state_i | input | NUM_LOC | Per-locality command-execution indication |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Locality in bits 14:12, register offset in bits 11:0 |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| cancel_o | output | 1 | One-cycle command-cancel request |
| estab_rst_o | output | 1 | One-cycle establishment-flag reset request |
| estab_loc_o | output | 3 | Locality that issued the establishment reset |

## Verification
Wrong stored state appears on `rdata_o` one cycle after the first read of the affected locality and offset. This covers a version captured at the wrong time, a family field that gets overwritten, or a lock bit that reaches only one locality. A wrong gating condition on the side effects appears on `cancel_o` or `estab_rst_o` one cycle after the offending status write. The reference model therefore reads every locality back after each kind of write, and compares the pulse outputs on every clock rather than only after writes.

// File: rtl/tis_pkg.sv
package tis_pkg;

    typedef enum logic [1:0] {
        VER_NONE = 2'd0,
        VER_12   = 2'd1,
        VER_20   = 2'd2,
        VER_RSVD = 2'd3
    } be_ver_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_STS,
        SEL_FIFO,
        SEL_IFID,
        SEL_DIDVID
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic [2:0] loc;
        reg_sel_e sel;
    } dec_t;

    localparam int LOC_LSB = 12;
    localparam int OFF_W   = 12;

    localparam logic [OFF_W-1:0] OFF_CAP    = 12'h014;
    localparam logic [OFF_W-1:0] OFF_STS    = 12'h018;
    localparam logic [OFF_W-1:0] OFF_FIFO   = 12'h024;
    localparam logic [OFF_W-1:0] OFF_IFID   = 12'h030;
    localparam logic [OFF_W-1:0] OFF_DIDVID = 12'hF00;

    localparam int STS_ST_DONE_BIT = 2;
    localparam int STS_FAM_LSB     = 26;
    localparam int STS_CANCEL_BIT  = 24;
    localparam int STS_ESTAB_BIT   = 25;
    localparam int IFID_LOCK_BIT   = 19;

    localparam logic [31:0] STS_KEEP_MASK = 32'h0C00_0004;
    localparam logic [31:0] STS_WR_MASK   = 32'h0000_0062;

    localparam logic [31:0] CAP_INT_LOW   = 32'h1 << 4;
    localparam logic [31:0] CAP_XFER_64   = 32'h3 << 9;
    localparam logic [31:0] CAP_INTS      = 32'h0000_0087;
    localparam logic [31:0] CAP_COMMON    = CAP_INT_LOW | CAP_XFER_64 | CAP_INTS;

    function automatic logic [31:0] cap_word(be_ver_e v);
        case (v)
            VER_12:  return CAP_COMMON | (32'h2 << 28);
            VER_20:  return CAP_COMMON | (32'h3 << 28);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] sts_reset(be_ver_e v);
        case (v)
            VER_20:  return 32'h1 << STS_FAM_LSB;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] ifid_reset(be_ver_e v);
        case (v)
            VER_12:  return 32'hFFFF_FFFF;
            VER_20:  return (32'h1 << 8) | (32'h1 << 13);
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/tis_addr_dec.sv
module tis_addr_dec
    import tis_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int NUM_LOC = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);
    logic [2:0]       loc;
    logic [OFF_W-1:0] off;

    assign loc = addr_i[LOC_LSB +: 3];
    assign off = addr_i[OFF_W-1:0];

    always_comb begin
        dec_o.loc = loc;
        dec_o.hit = (32'(loc) < NUM_LOC);
        case (off)
            OFF_CAP:    dec_o.sel = SEL_CAP;
            OFF_STS:    dec_o.sel = SEL_STS;
            OFF_FIFO:   dec_o.sel = SEL_FIFO;
            OFF_IFID:   dec_o.sel = SEL_IFID;
            OFF_DIDVID: dec_o.sel = SEL_DIDVID;
            default:    dec_o.sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/tis_loc_regs.sv
module tis_loc_regs
    import tis_pkg::*;
#(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  be_ver_e            ver_i,
    input  logic [NUM_LOC-1:0] wr_sts_i,
    input  logic               lock_set_i,
    input  logic [31:0]        wdata_i,
    input  logic               st_done_i,
    output logic [31:0]        sts_o  [NUM_LOC],
    output logic [31:0]        ifid_o [NUM_LOC]
);
    localparam logic [31:0] ST_DONE = 32'h1 << STS_ST_DONE_BIT;

    for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
        logic [31:0] sts_q, sts_nxt;
        logic [31:0] ifid_q;

        always_comb begin
            sts_nxt = sts_q;
            if (wr_sts_i[i]) begin
                sts_nxt = (sts_q & STS_KEEP_MASK) | (wdata_i & STS_WR_MASK);
            end
            if (st_done_i) begin
                sts_nxt = sts_nxt | ST_DONE;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q  <= sts_reset(ver_i);
                ifid_q <= ifid_reset(ver_i);
            end else begin
                sts_q <= sts_nxt;
                if (lock_set_i) begin
                    ifid_q[IFID_LOCK_BIT] <= 1'b1;
                end
            end
        end

        assign sts_o[i]  = sts_q;
        assign ifid_o[i] = ifid_q;
    end
endmodule

// File: rtl/tis_side_fx.sv
module tis_side_fx
    import tis_pkg::*;
#(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  be_ver_e            ver_i,
    input  logic [NUM_LOC-1:0] wr_sts_i,
    input  logic [NUM_LOC-1:0] exec_i,
    input  logic [2:0]         loc_i,
    input  logic               cancel_bit_i,
    input  logic               estab_bit_i,
    output logic               cancel_o,
    output logic               estab_o,
    output logic [2:0]         estab_loc_o
);
    logic v20, do_cancel, do_estab, loc_ok;

    assign v20       = (ver_i == VER_20);
    assign loc_ok    = (loc_i == 3'd3) || (loc_i == 3'd4);
    assign do_cancel = v20 && cancel_bit_i && |(wr_sts_i & exec_i);
    assign do_estab  = v20 && estab_bit_i && |wr_sts_i && loc_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cancel_o    <= 1'b0;
            estab_o     <= 1'b0;
            estab_loc_o <= 3'd0;
        end else begin
            cancel_o    <= do_cancel;
            estab_o     <= do_estab;
            estab_loc_o <= do_estab ? loc_i : 3'd0;
        end
    end
endmodule

// File: rtl/tis_regfront.sv
module tis_regfront
    import tis_pkg::*;
#(
    parameter int          ADDR_W    = 15,
    parameter int          NUM_LOC   = 5,
    parameter logic [15:0] DEVICE_ID = 16'h0001,
    parameter logic [15:0] VENDOR_ID = 16'h1014
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         be_ver_i,
    input  logic               selftest_done_i,
    input  logic [NUM_LOC-1:0] exec_state_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [31:0]        wdata_i,
    output logic               rvalid_o,
    output logic [31:0]        rdata_o,
    output logic               cancel_o,
    output logic               estab_rst_o,
    output logic [2:0]         estab_loc_o
);
    be_ver_e ver_q, ver_eff;
    dec_t    dec;

    logic               wr_sts_any, lock_set;
    logic [NUM_LOC-1:0] wr_sts_vec;
    logic [31:0]        sts  [NUM_LOC];
    logic [31:0]        ifid [NUM_LOC];
    logic [31:0]        rd_word;

    logic [NUM_LOC-1:0]   lock_vec;
    logic [2*NUM_LOC-1:0] fam_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            ver_q <= be_ver_e'(be_ver_i);
        end
    end

    assign ver_eff = rst ? be_ver_e'(be_ver_i) : ver_q;

    tis_addr_dec #(.ADDR_W(ADDR_W), .NUM_LOC(NUM_LOC)) u_dec (
        .addr_i (addr_i),
        .dec_o  (dec)
    );

    assign wr_sts_any = wr_en_i && dec.hit && (dec.sel == SEL_STS);
    assign lock_set   = wr_en_i && dec.hit && (dec.sel == SEL_IFID) && wdata_i[IFID_LOCK_BIT];

    always_comb begin
        for (int i = 0; i < NUM_LOC; i++) begin
            wr_sts_vec[i] = wr_sts_any && (dec.loc == 3'(i));
        end
    end

    tis_loc_regs #(.NUM_LOC(NUM_LOC)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .ver_i      (ver_eff),
        .wr_sts_i   (wr_sts_vec),
        .lock_set_i (lock_set),
        .wdata_i    (wdata_i),
        .st_done_i  (selftest_done_i),
        .sts_o      (sts),
        .ifid_o     (ifid)
    );

    tis_side_fx #(.NUM_LOC(NUM_LOC)) u_fx (
        .clk          (clk),
        .rst          (rst),
        .ver_i        (ver_q),
        .wr_sts_i     (wr_sts_vec),
        .exec_i       (exec_state_i),
        .loc_i        (dec.loc),
        .cancel_bit_i (wdata_i[STS_CANCEL_BIT]),
        .estab_bit_i  (wdata_i[STS_ESTAB_BIT]),
        .cancel_o     (cancel_o),
        .estab_o      (estab_rst_o),
        .estab_loc_o  (estab_loc_o)
    );

    always_comb begin
        for (int i = 0; i < NUM_LOC; i++) begin
            lock_vec[i]         = ifid[i][IFID_LOCK_BIT];
            fam_vec[2*i +: 2]   = sts[i][STS_FAM_LSB +: 2];
        end
    end

    always_comb begin
        rd_word = 32'h0;
        if (dec.hit) begin
            case (dec.sel)
                SEL_CAP:    rd_word = cap_word(ver_q);
                SEL_STS:    rd_word = sts[dec.loc];
                SEL_IFID:   rd_word = ifid[dec.loc];
                SEL_DIDVID: rd_word = {DEVICE_ID, VENDOR_ID};
                default:    rd_word = 32'h0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_o <= 1'b0;
            rdata_o  <= 32'h0;
        end else begin
            rvalid_o <= rd_en_i;
            if (rd_en_i) begin
                rdata_o <= rd_word;
            end
        end
    end
endmodule

// File: rtl/tis_regfront_chk.sv
module tis_regfront_chk
    import tis_pkg::*;
#(
    parameter int NUM_LOC = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en_i,
    input logic                 rd_en_i,
    input logic [11:0]          off_i,
    input logic [31:0]          wdata_i,
    input be_ver_e              ver_q,
    input logic                 rvalid_o,
    input logic                 cancel_o,
    input logic                 estab_rst_o,
    input logic [2:0]           estab_loc_o,
    input logic [NUM_LOC-1:0]   lock_vec,
    input logic [2*NUM_LOC-1:0] fam_vec
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    p_ver_hold_r1: assert property (@(posedge clk) disable iff (rst || !armed)
        $stable(ver_q));

    p_fam_hold_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        $stable(fam_vec));

    p_lock_all_r6: assert property (@(posedge clk) disable iff (rst)
        (lock_vec == '0) || (&lock_vec));

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(|lock_vec) |-> (&lock_vec));

    p_cancel_cause_r7: assert property (@(posedge clk) disable iff (rst || !armed)
        cancel_o |-> ($past(wr_en_i) && $past(off_i) == OFF_STS
                      && $past(wdata_i[STS_CANCEL_BIT]) && ver_q == VER_20));

    p_estab_loc_r8: assert property (@(posedge clk) disable iff (rst)
        estab_rst_o |-> ((estab_loc_o == 3'd3 || estab_loc_o == 3'd4) && ver_q == VER_20));

    p_rd_latency_r11: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rvalid_o);
endmodule

bind tis_regfront tis_regfront_chk #(.NUM_LOC(NUM_LOC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .off_i       (addr_i[11:0]),
    .wdata_i     (wdata_i),
    .ver_q       (ver_q),
    .rvalid_o    (rvalid_o),
    .cancel_o    (cancel_o),
    .estab_rst_o (estab_rst_o),
    .estab_loc_o (estab_loc_o),
    .lock_vec    (lock_vec),
    .fam_vec     (fam_vec)
);

// File: tb/tis_regfront_bench.sv
`timescale 1ns/1ps
module tis_regfront_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  be_ver = 2'd0;
    logic        st_done = 1'b0;
    logic [4:0]  exec_st = 5'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [14:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rvalid, cancel, estab;
    logic [31:0] rdata;
    logic [2:0]  estab_loc;

    int vectors = 0, miscompares = 0;
    bit done = 0;

    int          ver_m;
    logic [31:0] sts_m  [5];
    logic [31:0] ifid_m [5];

    always #10 clk = ~clk;

    tis_regfront u_tis_regfront (
        .clk (clk), .rst (rst), .be_ver_i (be_ver), .selftest_done_i (st_done),
        .exec_state_i (exec_st), .wr_en_i (wr_en), .rd_en_i (rd_en),
        .addr_i (addr), .wdata_i (wdata), .rvalid_o (rvalid), .rdata_o (rdata),
        .cancel_o (cancel), .estab_rst_o (estab), .estab_loc_o (estab_loc)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cap_m();
        if (ver_m == 1) return 32'h2000_0697;
        if (ver_m == 2) return 32'h3000_0697;
        return 32'h0;
    endfunction

    function automatic logic [31:0] read_m(int l, int off);
        if (l >= 5) return 32'h0;
        case (off)
            'h014:   return cap_m();
            'h018:   return sts_m[l];
            'h030:   return ifid_m[l];
            'hF00:   return 32'h0001_1014;
            default: return 32'h0;
        endcase
    endfunction

    task automatic do_reset(input int v, input string tag);
        @(negedge clk);
        rst = 1'b1; be_ver = v[1:0]; wr_en = 0; rd_en = 0; st_done = 0;
        @(posedge clk); #5;
        check(rvalid == 1'b0, tag, "rvalid in reset", 32'(rvalid), 0);
        check(cancel == 1'b0 && estab == 1'b0, tag, "pulses in reset", 32'({cancel, estab}), 0);
        @(negedge clk);
        rst = 1'b0;
        ver_m = (v == 3) ? 0 : v;
        for (int i = 0; i < 5; i++) begin
            sts_m[i]  = (ver_m == 2) ? 32'h0400_0000 : 32'h0;
            ifid_m[i] = (ver_m == 1) ? 32'hFFFF_FFFF : (ver_m == 2) ? 32'h0000_2100 : 32'h0;
        end
    endtask

    // One clock: drive inputs, predict, compare 5 ns after the rising edge.
    task automatic step(input bit we, input bit re, input int l, input int off,
                        input logic [31:0] d, input bit st, input string tag);
        logic [31:0] e_rd;
        bit e_can, e_est;
        int e_loc;
        wr_en = we; rd_en = re; addr = 15'((l << 12) | off); wdata = d; st_done = st;
        e_rd = read_m(l, off);
        e_can = 0; e_est = 0; e_loc = 0;
        if (we && l < 5 && off == 'h018) begin
            if (ver_m == 2 && d[24] && exec_st[l]) e_can = 1;
            if (ver_m == 2 && d[25] && (l == 3 || l == 4)) begin
                e_est = 1; e_loc = l;
            end
            sts_m[l] = (sts_m[l] & 32'h0C00_0004) | (d & 32'h0000_0062);
        end
        if (we && l < 5 && off == 'h030 && d[19])
            for (int i = 0; i < 5; i++) ifid_m[i][19] = 1'b1;
        if (st)
            for (int i = 0; i < 5; i++) sts_m[i][2] = 1'b1;
        @(posedge clk); #5;
        check(rvalid == re, tag, "rvalid", 32'(rvalid), 32'(re));
        if (re) check(rdata == e_rd, tag, "rdata", rdata, e_rd);
        check(cancel == e_can, tag, "cancel", 32'(cancel), 32'(e_can));
        check(estab == e_est, tag, "estab", 32'(estab), 32'(e_est));
        if (e_est) check(estab_loc == 3'(e_loc), tag, "estab_loc", 32'(estab_loc), e_loc);
        @(negedge clk);
        wr_en = 0; rd_en = 0; st_done = 0;
    endtask

    task automatic read_all(input string tag);
        for (int l = 0; l < 5; l++) begin
            step(0, 1, l, 'h018, 0, 0, tag);
            step(0, 1, l, 'h030, 0, 0, tag);
        end
    endtask

    initial begin
        // Version 2.0
        do_reset(2, "R11");
        step(0, 1, 0, 'h014, 0, 0, "R2");
        read_all("R3");
        read_all("R5");
        step(0, 1, 2, 'hF00, 0, 0, "R9");
        step(0, 1, 2, 'h024, 0, 0, "R9");
        step(0, 1, 2, 'h100, 0, 0, "R9");
        step(1, 1, 0, 'h018, 32'hFFFF_FFFF, 0, "R4");   // read sees old value
        step(0, 1, 0, 'h018, 0, 0, "R4");
        step(1, 0, 1, 'h018, 32'h0000_0040, 0, "R4");
        step(0, 1, 1, 'h018, 0, 0, "R4");
        exec_st = 5'b00010;
        step(1, 0, 1, 'h018, 32'h0100_0000, 0, "R7");
        step(0, 0, 0, 'h000, 0, 0, "R7");                // pulse lasts one cycle
        step(1, 0, 2, 'h018, 32'h0100_0000, 0, "R7");    // locality 2 not executing
        exec_st = 5'b11111;
        step(1, 0, 4, 'h018, 32'h0100_0000, 0, "R7");
        exec_st = 5'd0;
        step(1, 0, 3, 'h018, 32'h0200_0000, 0, "R8");
        step(1, 0, 4, 'h018, 32'h0200_0000, 0, "R8");
        step(1, 0, 2, 'h018, 32'h0200_0000, 0, "R8");
        step(1, 0, 0, 'h018, 32'h0200_0000, 0, "R8");
        step(0, 0, 0, 'h000, 0, 1, "R12");
        step(1, 0, 2, 'h018, 32'h0000_0000, 0, "R12");
        read_all("R12");
        step(1, 0, 2, 'h030, 32'hFFF7_FFFF, 0, "R6");    // lock clear: ignored
        read_all("R6");
        step(1, 0, 2, 'h030, 32'h0008_0000, 0, "R6");
        read_all("R6");
        step(1, 0, 4, 'h030, 32'h0000_0000, 0, "R6");
        read_all("R6");
        for (int l = 5; l < 8; l++) begin
            step(1, 0, l, 'h018, 32'h0300_0062, 0, "R10");
            step(1, 0, l, 'h030, 32'hFFFF_FFFF, 0, "R10");
            step(0, 1, l, 'h014, 0, 0, "R10");
            step(0, 1, l, 'hF00, 0, 0, "R10");
        end
        read_all("R10");
        be_ver = 2'd1;
        step(0, 1, 3, 'h014, 0, 0, "R1");
        step(1, 0, 3, 'h018, 32'h0200_0000, 0, "R1");
        // Version 1.2
        do_reset(1, "R11");
        step(0, 1, 0, 'h014, 0, 0, "R2");
        read_all("R5");
        exec_st = 5'b11111;
        step(1, 0, 3, 'h018, 32'h0300_0020, 0, "R7");
        step(1, 0, 4, 'h018, 32'h0200_0000, 0, "R8");
        read_all("R3");
        be_ver = 2'd2;
        step(0, 1, 1, 'h014, 0, 0, "R1");
        step(1, 0, 4, 'h018, 32'h0300_0000, 0, "R1");
        // Unspecified
        do_reset(0, "R11");
        step(0, 1, 4, 'h014, 0, 0, "R2");
        read_all("R5");
        step(1, 0, 3, 'h018, 32'h0300_0000, 0, "R8");
        read_all("R3");
        // Reserved code behaves as unspecified
        do_reset(3, "R1");
        step(0, 1, 0, 'h014, 0, 0, "R2");
        step(1, 0, 4, 'h018, 32'h0300_0000, 0, "R7");
        exec_st = 5'd0;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule